// File: doc/BRIEF.md
# Serial TDM Time Slot Interchanger

This block moves 8-bit channels between eight bidirectional serial TDM lines and one byte-wide parallel stream. Each serial line is clocked one bit per `clk` cycle. A frame starts on the cycle in which `fp_i` is high. Depending on `rate_sel`, a frame holds 32, 64 or 128 channels per line. At the fastest rate only the lower four lines carry traffic, so a frame never holds more than 512 serial channels.

Incoming serial bytes are collected into a two-page data memory. Parallel bytes presented on `pdi` in the first 32 positions of a frame go into a second two-page data memory. Both memories swap pages at every frame pulse. Everything gathered during one frame is therefore sent during the next frame, and all channels of a wideband group stay together.

Two connection memories decide what is sent:
- One entry per serial channel sets the direction of the pin, whether it is driven, and whether it carries a parallel byte or a fixed message byte.
- One entry per parallel slot chooses which stored serial channel, or which message byte, appears on `pdo`.

Software loads the connection memories through a write-only word port.

Top module: `tsi_switch`

## Requirements
- R1: After reset, every bit of `sio_oe` and `pdo_oe` stays low until the first cycle with `fp_i` high, even when the connection memories already enable outputs. Reset clears every connection memory entry to zero, which means input, not driven.
- R2: The cycle with `fp_i` high is frame position 0. The position then advances by one per clock and wraps to 0 after 256, 512 or 1024 positions for `rate_sel` 0, 1 or 2. The value 3 behaves as 2. Parallel slot p occupies position p.
- R3: Serial channel c occupies positions 8c to 8c+7. Bits travel most significant bit first on both `sio_i` and `sio_o`.
- R4: A serial channel's identifier is channel*8+line when `rate_sel` is 0 or 1, and channel*4+line when it is 2. At `rate_sel` 2, lines 4 to 7 are never driven and never stored.
- R5: A parallel slot whose entry has drive=1 and message=0 puts on `pdo`, with `pdo_oe` high, the byte received in the previous frame on the serial channel whose identifier is the entry's source.
- R6: A serial channel whose entry has direction=1, drive=1 and message=0 drives the byte that arrived on `pdi` in the previous frame at the parallel slot named by the low five source bits. `sio_oe` is high for all eight bits of that channel.
- R7: With message=1, the entry's data byte is sent in place of switched data. This holds on both the serial and the parallel side.
- R8: A serial channel with direction=0 (input), or with direction=1 and drive=0, leaves `sio_oe` low. The setting applies only to the eight positions of that channel on that line.
- R9: `pdo_oe` is low for a slot whose entry has drive=0, whatever its direction bit. It is also low at every position of 32 or more.
- R10: Data pages swap only at a frame pulse. Every byte sent during a frame comes from the frame that ended at that pulse, including bytes that arrived after the slot that sends them.
- R11: A connection memory write happens on a clock with `cm_we` high. `cm_sel`=0 writes the serial entry at `cm_addr`. `cm_sel`=1 writes the parallel entry at `cm_addr[4:0]`, and the upper address bits are ignored. Word layout:
  - bit 19: direction (1 = output)
  - bit 18: drive
  - bit 17: message
  - bits 16:8: source
  - bits 7:0: message byte

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one serial bit and one frame position per cycle |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 2 | Serial rate: 0 = 32, 1 = 64, 2 or 3 = 128 channels per line |
| fp_i | input | 1 | Frame pulse, high on position 0 |
| sio_i | input | 8 | Serial line input values, one bit per line |
| sio_o | output | 8 | Serial line output values |
| sio_oe | output | 8 | Serial line drive enables, high = driving |
| pdi | input | 8 | Parallel byte in, sampled at positions 0 to 31 |
| pdo | output | 8 | Parallel byte out |
| pdo_oe | output | 1 | Parallel output drive enable |
| cm_we | input | 1 | Connection memory write strobe |
| cm_sel | input | 1 | Connection memory select: 0 serial, 1 parallel |
| cm_addr | input | 9 | Connection memory entry address |
| cm_wdata | input | 20 | Connection memory entry word |

## Verification
The assertions assume three things about the inputs:
- Frame pulses come no more often than one frame length apart, so line writes at the same position never share an identifier.
- `rate_sel` changes only on a frame pulse cycle.
- The connection memories are written only between data bytes whose enables are being checked.

The stimulus keeps to these assumptions. It pulses `fp_i` at exactly the frame length for the selected rate. It changes `rate_sel` only together with a pulse, and it loads the connection memories before the first pulse.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    localparam int DEF_NSTR   = 8;
    localparam int DEF_TOTCH  = 512;
    localparam int DEF_PSLOTS = 32;
    localparam int CM_FLAGS   = 3;
    localparam int BYTE_W     = 8;

    typedef enum logic [1:0] {
        RATE_LO  = 2'd0,
        RATE_MID = 2'd1,
        RATE_HI  = 2'd2
    } rate_e;

    // Code 3 is treated as the fastest rate.
    function automatic rate_e eff_rate(input logic [1:0] sel);
        case (sel)
            2'd0:    return RATE_LO;
            2'd1:    return RATE_MID;
            default: return RATE_HI;
        endcase
    endfunction

endpackage

// File: rtl/tsi_timing.sv
module tsi_timing
    import tsi_pkg::*;
#(
    parameter int BASEW = 8,
    localparam int POSW = BASEW + 2
)(
    input  logic            clk,
    input  logic            rst,
    input  rate_e           rate_eff,
    input  logic            fp_i,
    output logic [POSW-1:0] pos,
    output logic            wr_pg,
    output logic            synced
);

    typedef struct packed {
        logic [POSW-1:0] cnt;
        logic            pg;
        logic            sync;
    } tim_t;

    tim_t st_d, st_q;
    logic [POSW-1:0] last_pos;

    always_comb begin
        int flen;
        flen     = 1 << (BASEW + int'(rate_eff));
        last_pos = POSW'(flen - 1);
        st_d     = st_q;
        if (fp_i) begin
            pos = '0;
        end else if (st_q.cnt >= last_pos) begin
            pos = '0;
        end else begin
            pos = st_q.cnt + POSW'(1);
        end
        st_d.cnt  = pos;
        st_d.pg   = fp_i ? ~st_q.pg : st_q.pg;
        st_d.sync = st_q.sync | fp_i;
        wr_pg     = st_d.pg;
        synced    = st_d.sync;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: a frame pulse leaves position 0 registered.
    p_pulse_zero_r2: assert property (@(posedge clk) disable iff (rst)
        fp_i |=> (st_q.cnt == '0));

    // R10: the page flips on a pulse ...
    p_page_flip_r10: assert property (@(posedge clk) disable iff (rst)
        fp_i |=> (st_q.pg != $past(st_q.pg)));

    // R10: ... and holds otherwise.
    p_page_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !fp_i |=> $stable(st_q.pg));

endmodule

// File: rtl/tsi_dmem.sv
module tsi_dmem #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int NWR   = 1,
    parameter int NRD   = 1,
    localparam int AW   = $clog2(DEPTH)
)(
    input  logic                     clk,
    input  logic [NWR-1:0]           we,
    input  logic                     wpg,
    input  logic [NWR-1:0][AW-1:0]   waddr,
    input  logic [NWR-1:0][DW-1:0]   wdata,
    input  logic                     rpg,
    input  logic [NRD-1:0][AW-1:0]   raddr,
    output logic [NRD-1:0][DW-1:0]   rdata
);

    logic [DW-1:0] mem_q [2][DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NWR; i++) begin
            if (we[i]) begin
                mem_q[wpg][waddr[i]] <= wdata[i];
            end
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = mem_q[rpg][raddr[g]];
    end

    // R4: line identifiers written in one cycle are distinct.
    for (genvar a = 0; a < NWR; a++) begin : g_ca
        for (genvar b = a + 1; b < NWR; b++) begin : g_cb
            p_no_clash_r4: assert property (@(posedge clk)
                (we[a] && we[b]) |-> (waddr[a] != waddr[b]));
        end
    end

endmodule

// File: rtl/tsi_cmem.sv
module tsi_cmem #(
    parameter int DEPTH = 32,
    parameter int W     = 16,
    parameter int NRD   = 1,
    localparam int AW   = $clog2(DEPTH)
)(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [W-1:0]            wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][W-1:0]   rdata
);

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = mem_q[raddr[g]];
    end

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int NSTR   = DEF_NSTR,
    parameter int TOTCH  = DEF_TOTCH,
    parameter int PSLOTS = DEF_PSLOTS,
    localparam int CHW   = $clog2(TOTCH),
    localparam int CMW   = CM_FLAGS + CHW + BYTE_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        rate_sel,
    input  logic              fp_i,
    input  logic [NSTR-1:0]   sio_i,
    output logic [NSTR-1:0]   sio_o,
    output logic [NSTR-1:0]   sio_oe,
    input  logic [BYTE_W-1:0] pdi,
    output logic [BYTE_W-1:0] pdo,
    output logic              pdo_oe,
    input  logic              cm_we,
    input  logic              cm_sel,
    input  logic [CHW-1:0]    cm_addr,
    input  logic [CMW-1:0]    cm_wdata
);

    localparam int CH0   = TOTCH / (2 * NSTR);
    localparam int BASEW = $clog2(CH0 * 8);
    localparam int POSW  = BASEW + 2;
    localparam int CHNW  = POSW - 3;
    localparam int PSW   = $clog2(PSLOTS);
    localparam int SW_W  = 3 + PSW + BYTE_W;
    localparam int PW_W  = 2 + CHW + BYTE_W;

    typedef struct packed {
        logic              dir;
        logic              drv;
        logic              msg;
        logic [PSW-1:0]    src;
        logic [BYTE_W-1:0] data;
    } scw_t;

    typedef struct packed {
        logic              drv;
        logic              msg;
        logic [CHW-1:0]    src;
        logic [BYTE_W-1:0] data;
    } pcw_t;

    typedef struct packed {
        logic [NSTR-1:0][6:0] sh;
    } sw_st_t;

    // ---------------- timing ----------------
    rate_e           rate_eff;
    logic [POSW-1:0] pos;
    logic            wr_pg;
    logic            rd_pg;
    logic            synced;
    logic [CHNW-1:0] chan;
    logic [2:0]      bitn;
    logic            wide;
    logic            in_slot;

    assign rate_eff = eff_rate(rate_sel);
    assign wide     = (rate_eff == RATE_HI);

    tsi_timing #(.BASEW(BASEW)) i_timing (
        .clk      (clk),
        .rst      (rst),
        .rate_eff (rate_eff),
        .fp_i     (fp_i),
        .pos      (pos),
        .wr_pg    (wr_pg),
        .synced   (synced)
    );

    assign rd_pg   = ~wr_pg;
    assign chan    = pos[POSW-1:3];
    assign bitn    = pos[2:0];
    assign in_slot = (int'(pos) < PSLOTS);

    function automatic logic [CHW-1:0] chan_id(input logic [CHNW-1:0] ch,
                                               input int s, input logic w);
        int v;
        v = w ? (int'(ch) * (NSTR / 2) + s) : (int'(ch) * NSTR + s);
        return CHW'(v);
    endfunction

    // ---------------- connection memory words ----------------
    logic [SW_W-1:0] scm_wword;
    logic [PW_W-1:0] pcm_wword;

    assign scm_wword = {cm_wdata[CHW+10], cm_wdata[CHW+9], cm_wdata[CHW+8],
                        cm_wdata[PSW+7:8], cm_wdata[7:0]};
    assign pcm_wword = cm_wdata[CHW+9:0];

    logic [NSTR-1:0][CHW-1:0]  scm_raddr;
    logic [NSTR-1:0][SW_W-1:0] scm_rd;
    logic [0:0][PSW-1:0]       pcm_raddr;
    logic [0:0][PW_W-1:0]      pcm_rd;

    tsi_cmem #(.DEPTH(TOTCH), .W(SW_W), .NRD(NSTR)) i_scm (
        .clk   (clk),
        .rst   (rst),
        .we    (cm_we & ~cm_sel),
        .waddr (cm_addr),
        .wdata (scm_wword),
        .raddr (scm_raddr),
        .rdata (scm_rd)
    );

    tsi_cmem #(.DEPTH(PSLOTS), .W(PW_W), .NRD(1)) i_pcm (
        .clk   (clk),
        .rst   (rst),
        .we    (cm_we & cm_sel),
        .waddr (cm_addr[PSW-1:0]),
        .wdata (pcm_wword),
        .raddr (pcm_raddr),
        .rdata (pcm_rd)
    );

    // ---------------- deserialiser state ----------------
    sw_st_t st_d, st_q;

    logic [NSTR-1:0]              sdm_we;
    logic [NSTR-1:0][CHW-1:0]     sdm_waddr;
    logic [NSTR-1:0][BYTE_W-1:0]  sdm_wdata;
    logic [0:0][CHW-1:0]          sdm_raddr;
    logic [0:0][BYTE_W-1:0]       sdm_rd;

    logic [0:0]                   pdm_we;
    logic [0:0][PSW-1:0]          pdm_waddr;
    logic [0:0][BYTE_W-1:0]       pdm_wdata;
    logic [NSTR-1:0][PSW-1:0]     pdm_raddr;
    logic [NSTR-1:0][BYTE_W-1:0]  pdm_rd;

    logic [NSTR-1:0]              active;

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < NSTR; s++) begin
            st_d.sh[s] = {st_q.sh[s][5:0], sio_i[s]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- per-line serial logic ----------------
    for (genvar g = 0; g < NSTR; g++) begin : g_line
        scw_t              sw;
        logic [BYTE_W-1:0] obyte;

        assign active[g]    = (g < NSTR / 2) || !wide;
        assign scm_raddr[g] = chan_id(chan, g, wide);
        assign sw           = scw_t'(scm_rd[g]);
        assign pdm_raddr[g] = sw.src;
        assign obyte        = sw.msg ? sw.data : pdm_rd[g];
        assign sio_o[g]     = obyte[3'd7 - bitn];
        assign sio_oe[g]    = synced & active[g] & sw.dir & sw.drv;

        assign sdm_we[g]    = synced & active[g] & (bitn == 3'd7);
        assign sdm_waddr[g] = chan_id(chan, g, wide);
        assign sdm_wdata[g] = {st_q.sh[g], sio_i[g]};
    end

    tsi_dmem #(.DEPTH(TOTCH), .DW(BYTE_W), .NWR(NSTR), .NRD(1)) i_sdm (
        .clk   (clk),
        .we    (sdm_we),
        .wpg   (wr_pg),
        .waddr (sdm_waddr),
        .wdata (sdm_wdata),
        .rpg   (rd_pg),
        .raddr (sdm_raddr),
        .rdata (sdm_rd)
    );

    // ---------------- parallel side ----------------
    pcw_t pw;

    assign pcm_raddr[0] = pos[PSW-1:0];
    assign pw           = pcw_t'(pcm_rd[0]);
    assign sdm_raddr[0] = pw.src;
    assign pdo          = pw.msg ? pw.data : sdm_rd[0];
    assign pdo_oe       = synced & in_slot & pw.drv;

    assign pdm_we[0]    = synced & in_slot;
    assign pdm_waddr[0] = pos[PSW-1:0];
    assign pdm_wdata[0] = pdi;

    tsi_dmem #(.DEPTH(PSLOTS), .DW(BYTE_W), .NWR(1), .NRD(NSTR)) i_pdm (
        .clk   (clk),
        .we    (pdm_we),
        .wpg   (wr_pg),
        .waddr (pdm_waddr),
        .wdata (pdm_wdata),
        .rpg   (rd_pg),
        .raddr (pdm_raddr),
        .rdata (pdm_rd)
    );

    // ---------------- assertions ----------------
    // R1: nothing drives before the first frame pulse.
    p_quiet_unsynced_r1: assert property (@(posedge clk) disable iff (rst)
        !synced |-> (sio_oe == '0 && !pdo_oe));

    // R4: upper lines stay undriven at the fastest rate.
    p_upper_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        wide |-> (sio_oe[NSTR-1:NSTR/2] == '0));

    // R9: the parallel output drives only inside the slot window.
    p_pdo_window_r9: assert property (@(posedge clk) disable iff (rst)
        pdo_oe |-> (int'(pos) < PSLOTS));

    // R8: drive enables change only at channel boundaries.
    p_oe_per_channel_r8: assert property (@(posedge clk) disable iff (rst)
        (bitn != 3'd0 && !fp_i && !$past(cm_we) && $stable(rate_sel))
            |-> $stable(sio_oe));

endmodule

// File: tb/test_tsi_switch.sv
module test_tsi_switch;
    import tsi_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  rate_sel = 2'd0;
    logic        fp_i = 1'b0;
    logic [7:0]  sio_i = '0;
    logic [7:0]  sio_o;
    logic [7:0]  sio_oe;
    logic [7:0]  pdi = '0;
    logic [7:0]  pdo;
    logic        pdo_oe;
    logic        cm_we = 1'b0;
    logic        cm_sel = 1'b0;
    logic [8:0]  cm_addr = '0;
    logic [19:0] cm_wdata = '0;

    tsi_switch i_tsi_switch (.*);

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] cap_pdo [32];
    logic       cap_pen [32];
    logic [7:0] cap_ser [8][128];
    logic [7:0] cap_oe  [8][128];
    bit         cap_late;

    // Parallel table: slot[25:21], expected drive[20], then a word
    // dir[19] drv[18] msg[17] src[16:8] data[7:0].
    localparam int NTAB = 7;
    localparam logic [25:0] PTAB [NTAB] = '{
        {5'd0,  1'b1, 1'b0, 1'b1, 1'b0, 9'd43,  8'h00},
        {5'd1,  1'b1, 1'b0, 1'b1, 1'b1, 9'd0,   8'hA5},
        {5'd2,  1'b1, 1'b0, 1'b1, 1'b0, 9'd0,   8'h00},
        {5'd3,  1'b0, 1'b1, 1'b0, 1'b0, 9'd10,  8'h00},
        {5'd31, 1'b1, 1'b0, 1'b1, 1'b0, 9'd255, 8'h00},
        {5'd7,  1'b1, 1'b0, 1'b1, 1'b0, 9'd17,  8'h00},
        {5'd4,  1'b0, 1'b0, 1'b0, 1'b0, 9'd0,   8'h00}
    };

    function automatic logic [7:0] ser_byte(int k, int s, int ch);
        return 8'(k * 29 + s * 53 + ch * 7 + 3);
    endfunction

    function automatic logic [7:0] par_byte(int k, int p);
        return 8'(k * 41 + p * 13 + 5);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cm_write(input bit sel, input logic [8:0] addr, input logic [19:0] w);
        @(negedge clk);
        cm_we    = 1'b1;
        cm_sel   = sel;
        cm_addr  = addr;
        cm_wdata = w;
        @(negedge clk);
        cm_we    = 1'b0;
    endtask

    task automatic run_frame(input int k, input int len, input logic [1:0] rate);
        cap_late = 1'b0;
        for (int p = 0; p < len; p++) begin
            @(negedge clk);
            fp_i = (p == 0);
            if (p == 0) rate_sel = rate;
            for (int s = 0; s < 8; s++) begin
                logic [7:0] b;
                b = ser_byte(k, s, p / 8);
                sio_i[s] = b[7 - (p % 8)];
            end
            pdi = (p < 32) ? par_byte(k, p) : 8'h00;
            #1;
            if (p < 32) begin
                cap_pdo[p] = pdo;
                cap_pen[p] = pdo_oe;
            end else if (pdo_oe) begin
                cap_late = 1'b1;
            end
            for (int s = 0; s < 8; s++) begin
                cap_ser[s][p / 8][7 - (p % 8)] = sio_o[s];
                cap_oe[s][p / 8][p % 8]        = sio_oe[s];
            end
        end
    endtask

    task automatic chk_ser(input int s, input int ch, input bit eoe,
                           input logic [7:0] eb, input string req);
        if (eoe) begin
            chk(cap_oe[s][ch] == 8'hFF, req, int'(cap_oe[s][ch]), 255);
            chk(cap_ser[s][ch] == eb, req, int'(cap_ser[s][ch]), int'(eb));
        end else begin
            chk(cap_oe[s][ch] == 8'h00, req, int'(cap_oe[s][ch]), 0);
        end
    endtask

    // Parallel slots checked against the previous frame (R5 R7 R9 R10).
    task automatic chk_par(input int k, input int ns);
        for (int i = 0; i < NTAB; i++) begin
            int         slot;
            bit         eoe;
            bit         msg;
            int         src;
            logic [7:0] eb;
            slot = int'(PTAB[i][25:21]);
            eoe  = PTAB[i][20];
            msg  = PTAB[i][17];
            src  = int'(PTAB[i][16:8]);
            eb   = msg ? PTAB[i][7:0] : ser_byte(k - 1, src % ns, src / ns);
            chk(cap_pen[slot] == eoe, "R9 R5 parallel enable",
                int'(cap_pen[slot]), int'(eoe));
            if (eoe) begin
                chk(cap_pdo[slot] == eb, msg ? "R7 parallel message" : "R5 R10 parallel data",
                    int'(cap_pdo[slot]), int'(eb));
            end
        end
        chk(cap_late == 1'b0, "R9 late position drive", int'(cap_late), 0);
        chk(cap_pen[5] && cap_pdo[5] == 8'h5A, "R11 parallel address wrap",
            int'(cap_pdo[5]), 8'h5A);
    endtask

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(sio_oe == 8'h00, "R1 reset serial enable", int'(sio_oe), 0);
        chk(pdo_oe == 1'b0, "R1 reset parallel enable", int'(pdo_oe), 0);

        for (int i = 0; i < NTAB; i++) begin
            cm_write(1'b1, 9'(PTAB[i][25:21]), PTAB[i][19:0]);
        end
        cm_write(1'b1, 9'h025, {1'b0, 1'b1, 1'b1, 9'd0, 8'h5A});       // R11
        cm_write(1'b0, 9'd17,  {1'b1, 1'b1, 1'b0, 9'd4, 8'h00});
        cm_write(1'b0, 9'd2,   {1'b1, 1'b1, 1'b1, 9'd0, 8'h3C});
        cm_write(1'b0, 9'd12,  {1'b1, 1'b0, 1'b0, 9'd0, 8'h00});
        cm_write(1'b0, 9'd255, {1'b1, 1'b1, 1'b0, 9'd31, 8'h00});

        // R1: enabled entries stay quiet with no frame pulse yet.
        seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            #1;
            if (sio_oe != 0 || pdo_oe) seen = 1'b1;
        end
        chk(seen == 1'b0, "R1 quiet before pulse", int'(seen), 0);

        for (int k = 0; k < 4; k++) begin
            run_frame(k, 256, 2'd0);
            if (k >= 1) begin
                chk_par(k, 8);
                chk_ser(1, 2,  1'b1, par_byte(k - 1, 4),  "R6 R3 serial data");
                chk_ser(2, 0,  1'b1, 8'h3C,               "R7 serial message");
                chk_ser(4, 1,  1'b0, 8'h00,               "R8 drive off");
                chk_ser(7, 31, 1'b1, par_byte(k - 1, 31), "R6 R10 last channel");
                chk_ser(0, 3,  1'b0, 8'h00,               "R8 R1 default input");
                chk_ser(1, 1,  1'b0, 8'h00,               "R8 neighbour before");
                chk_ser(1, 3,  1'b0, 8'h00,               "R8 neighbour after");
            end
        end

        // Fastest rate: identifiers use four lines (R4, R2).
        run_frame(4, 1024, 2'd2);
        run_frame(5, 1024, 2'd2);
        chk_par(5, 4);
        chk_ser(1, 4,  1'b1, par_byte(4, 4),  "R4 R6 wide serial data");
        chk_ser(2, 0,  1'b1, 8'h3C,           "R4 R7 wide message");
        chk_ser(0, 3,  1'b0, 8'h00,           "R4 R8 wide drive off");
        chk_ser(3, 63, 1'b1, par_byte(4, 31), "R4 R2 wide channel 63");
        seen = 1'b0;
        for (int s = 4; s < 8; s++) begin
            for (int ch = 0; ch < 128; ch++) begin
                if (cap_oe[s][ch] != 0) seen = 1'b1;
            end
        end
        chk(seen == 1'b0, "R4 upper lines undriven", int'(seen), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule